// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block is the purely combinational arithmetic and logic unit of a small 8-bit microcontroller core. It receives two operands, a 5-bit operation code and the current status flags. In the same cycle it returns a result byte, a proposed new flag vector and a write mask. The mask tells the surrounding core which flags the operation is allowed to change.

Each flag that the mask does not select comes out equal to its incoming value. This lets the core write the whole flag vector back without any extra merge logic.

The block has no clock, no storage and no handshake. Operand fetch, instruction decode, immediate selection and 16-bit word arithmetic are handled outside it. It has no streaming interface, so it has no valid/ready pins and no back-pressure rules. The core samples the outputs in the same cycle it drives the inputs.

Top module: `alu8_core`

## Requirements
- R1: Add (op 0) returns a+b. Add-with-carry (op 1) returns a+b+C_in. The incoming carry has no effect on op 0. C is the carry out of bit 7 and H is the carry out of bit 3. V is set when both operands have the same sign and the result sign differs from it.
- R2: Subtract (op 2) returns a-b. Subtract-with-carry (op 3) returns a-b-C_in. C is the borrow out of bit 7 and H is the borrow out of bit 3. V is set when the operand signs differ and the result sign differs from a.
- R3: Compare (op 4) and compare-with-carry (op 5) set all flags exactly as op 2 and op 3 would. Their result output equals operand a unchanged, because the difference is discarded.
- R4: AND (op 6), OR (op 7) and XOR (op 8) return the bitwise result and force V to 0. C and H leave the block equal to their incoming values.
- R5: Increment (op 11) returns a+1 and decrement (op 12) returns a-1. V is set only for 0x7F incremented and for 0x80 decremented. C and H keep their incoming values.
- R6: One's complement (op 9) returns 0xFF minus a, sets C to 1 and clears V. H keeps its incoming value.
- R7: Two's complement (op 10) returns 0x00 minus a. It updates C, Z, N, V, S and H as a subtraction from zero.
- R8: Logical shift left (op 13) fills bit 0 with 0 and moves the old bit 7 into C. Logical shift right (op 14) fills bit 7 with 0 and moves the old bit 0 into C. V equals N XOR the new C, and H is kept.
- R9: Rotate left (op 15) puts the incoming C into bit 0 and the old bit 7 into C. Rotate right (op 16) puts the incoming C into bit 7 and the old bit 0 into C. V equals N XOR the new C, and H is kept.
- R10: For every updated flag set, Z is 1 exactly when the computed value is zero and N equals its bit 7. S equals N XOR V.
- R11: Flag bit positions are C=0, Z=1, N=2, V=3, S=4 and H=5. The write mask is 0x3F for ops 0-5 and 10, 0x1E for ops 6-8 and 11-12, and 0x1F for ops 9 and 13-16. Every flag outside the mask equals its incoming value. Op codes 17-31 return a, a mask of 0 and the incoming flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand; also the only operand of single-operand operations |
| opnd_b | input | 8 | Second operand |
| op_sel | input | 5 | Operation code (see R11 and the requirements) |
| flags_in | input | 6 | Current status flags {H,S,V,N,Z,C} |
| result | output | 8 | Result byte |
| flags_out | output | 6 | Next status flags, incoming value where unmasked |
| flags_we | output | 6 | Per-flag write mask |

## Verification
Every output is due in the same cycle as the stimulus that produces it, because no register lies between the inputs and the outputs. The bench applies each vector just after a rising clock edge and reads the outputs at the following falling edge. This leaves half a period for the logic to settle and keeps sampling clear of the active edge. Flag retention is checked at the ports by presetting incoming C and H to values that would differ from a freshly computed flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_CMPC = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_LSL  = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROL  = 5'd15,
    OP_ROR  = 5'd16
  } alu_op_e;

  localparam int FLAG_W = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef logic [FLAG_W-1:0] flags_t;

  localparam flags_t MASK_ARITH = 6'b111111;
  localparam flags_t MASK_LOGIC = 6'b011110;
  localparam flags_t MASK_SHIFT = 6'b011111;
  localparam flags_t MASK_NONE  = 6'b000000;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          h_out,
  output logic          v_out
);
  localparam int HB = DW / 2 - 1;
  localparam int MSB = DW - 1;

  logic [DW:0]   full;
  logic [HB+1:0] low;

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
      low  = {1'b0, x[HB:0]} - {1'b0, y[HB:0]} - {{(HB+1){1'b0}}, cin};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
      low  = {1'b0, x[HB:0]} + {1'b0, y[HB:0]} + {{(HB+1){1'b0}}, cin};
    end
    sum   = full[DW-1:0];
    c_out = full[DW];
    h_out = low[HB+1];
    if (sub) v_out = (x[MSB] != y[MSB]) && (full[MSB] != x[MSB]);
    else     v_out = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
  end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [1:0]    fn,
  output logic [DW-1:0] res
);
  always_comb begin
    unique case (fn)
      2'd0:    res = x & y;
      2'd1:    res = x | y;
      2'd2:    res = x ^ y;
      default: res = {DW{1'b1}} - x;
    endcase
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic          cin,
  input  logic          left,
  input  logic          thru_c,
  output logic [DW-1:0] res,
  output logic          c_out
);
  logic fill;

  always_comb begin
    fill = thru_c ? cin : 1'b0;
    if (left) begin
      res   = {x[DW-2:0], fill};
      c_out = x[DW-1];
    end else begin
      res   = {fill, x[DW-1:1]};
      c_out = x[0];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]     opnd_a,
  input  logic [DW-1:0]     opnd_b,
  input  logic [4:0]        op_sel,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] flags_out,
  output logic [FLAG_W-1:0] flags_we
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] as_x, as_y, as_sum;
  logic          as_cin, as_sub, as_c, as_h, as_v;
  logic [1:0]    bw_fn;
  logic [DW-1:0] bw_res;
  logic          sh_left, sh_thru, sh_c;
  logic [DW-1:0] sh_res;

  logic [DW-1:0] calc;
  flags_t        fresh;
  flags_t        mask;
  logic          is_cmp;
  logic          is_logic;
  logic          is_shift;
  logic          c_in;

  assign c_in = flags_in[FC];

  always_comb begin
    as_x   = opnd_a;
    as_y   = opnd_b;
    as_sub = 1'b0;
    as_cin = 1'b0;
    unique case (op_sel)
      OP_ADC:           as_cin = c_in;
      OP_SUB, OP_CMP:   as_sub = 1'b1;
      OP_SBC, OP_CMPC: begin
        as_sub = 1'b1;
        as_cin = c_in;
      end
      OP_NEG: begin
        as_x   = '0;
        as_y   = opnd_a;
        as_sub = 1'b1;
      end
      OP_INC: as_y = DW'(1);
      OP_DEC: begin
        as_y   = DW'(1);
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (op_sel)
      OP_OR:   bw_fn = 2'd1;
      OP_XOR:  bw_fn = 2'd2;
      OP_COM:  bw_fn = 2'd3;
      default: bw_fn = 2'd0;
    endcase
    sh_left = (op_sel == OP_LSL) || (op_sel == OP_ROL);
    sh_thru = (op_sel == OP_ROL) || (op_sel == OP_ROR);
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
  );

  alu8_bitwise #(.DW(DW)) u_bitwise (
    .x(opnd_a), .y(opnd_b), .fn(bw_fn), .res(bw_res)
  );

  alu8_shifter #(.DW(DW)) u_shifter (
    .x(opnd_a), .cin(c_in), .left(sh_left), .thru_c(sh_thru),
    .res(sh_res), .c_out(sh_c)
  );

  always_comb begin
    calc     = opnd_a;
    fresh    = flags_in;
    mask     = MASK_NONE;
    is_cmp   = 1'b0;
    is_logic = 1'b0;
    is_shift = 1'b0;
    unique case (op_sel)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG: begin
        calc      = as_sum;
        fresh[FC] = as_c;
        fresh[FH] = as_h;
        fresh[FV] = as_v;
        mask      = MASK_ARITH;
        is_cmp    = (op_sel == OP_CMP) || (op_sel == OP_CMPC);
      end
      OP_INC, OP_DEC: begin
        calc      = as_sum;
        fresh[FV] = as_v;
        mask      = MASK_LOGIC;
      end
      OP_AND, OP_OR, OP_XOR: begin
        calc      = bw_res;
        fresh[FV] = 1'b0;
        mask      = MASK_LOGIC;
        is_logic  = 1'b1;
      end
      OP_COM: begin
        calc      = bw_res;
        fresh[FC] = 1'b1;
        fresh[FV] = 1'b0;
        mask      = MASK_SHIFT;
        is_logic  = 1'b1;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR: begin
        calc      = sh_res;
        fresh[FC] = sh_c;
        fresh[FV] = sh_res[MSB] ^ sh_c;
        mask      = MASK_SHIFT;
        is_shift  = 1'b1;
      end
      default: ;
    endcase
    fresh[FZ] = (calc == '0);
    fresh[FN] = calc[MSB];
    fresh[FS] = fresh[FN] ^ fresh[FV];
  end

  assign result    = is_cmp ? opnd_a : calc;
  assign flags_we  = mask;
  assign flags_out = (fresh & mask) | (flags_in & ~mask);

  always_comb begin
    if (flags_we[FS]) begin
      AST_SIGN_IS_N_XOR_V: assert (flags_out[FS] == (flags_out[FN] ^ flags_out[FV])) else $error("sign flag mismatch"); // R10
    end
    if (flags_we[FZ] && !is_cmp) begin
      AST_ZERO_TRACKS_RESULT: assert (flags_out[FZ] == (result == '0)) else $error("zero flag mismatch"); // R10
      AST_NEG_TRACKS_MSB: assert (flags_out[FN] == result[MSB]) else $error("negative flag mismatch"); // R10
    end
    if (is_logic) begin
      AST_LOGIC_V_CLEAR: assert (!flags_out[FV] && flags_out[FH] == flags_in[FH]) else $error("logic op flag error"); // R4
    end
    if (is_shift) begin
      AST_SHIFT_V_RULE: assert (flags_out[FV] == (result[MSB] ^ flags_out[FC])) else $error("shift V rule broken"); // R8
    end
    if (is_cmp) begin
      AST_CMP_KEEPS_A: assert (result == opnd_a) else $error("compare altered result"); // R3
    end
    if (flags_we == '0) begin
      AST_NOOP_PASSES: assert (flags_out == flags_in && result == opnd_a) else $error("unused op changed state"); // R11
    end
  end
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  logic       clk = 1'b0;
  logic [7:0] opnd_a, opnd_b, result;
  logic [4:0] op_sel;
  logic [5:0] flags_in, flags_out, flags_we;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu8_core u0 (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .flags_in(flags_in),
    .result(result), .flags_out(flags_out), .flags_we(flags_we)
  );

  // {op, a, b, flags_in, exp_result, exp_flags, exp_mask}; flags {H,S,V,N,Z,C}
  localparam int NV = 25;
  localparam logic [46:0] VEC [NV] = '{
    {5'd0,  8'h0F, 8'h01, 6'h00, 8'h10, 6'h20, 6'h3F}, // R1 half carry
    {5'd0,  8'h80, 8'h80, 6'h00, 8'h00, 6'h1B, 6'h3F}, // R1 carry, overflow, R10 zero
    {5'd1,  8'h7F, 8'h00, 6'h01, 8'h80, 6'h2C, 6'h3F}, // R1 carry in used
    {5'd0,  8'h01, 8'h01, 6'h01, 8'h02, 6'h00, 6'h3F}, // R1 carry in ignored
    {5'd2,  8'h10, 8'h01, 6'h00, 8'h0F, 6'h20, 6'h3F}, // R2 half borrow
    {5'd3,  8'h00, 8'h00, 6'h01, 8'hFF, 6'h35, 6'h3F}, // R2 borrow in
    {5'd2,  8'h80, 8'h01, 6'h00, 8'h7F, 6'h38, 6'h3F}, // R2 overflow
    {5'd4,  8'h05, 8'h05, 6'h00, 8'h05, 6'h02, 6'h3F}, // R3 equal
    {5'd5,  8'h05, 8'h07, 6'h01, 8'h05, 6'h35, 6'h3F}, // R3 with carry
    {5'd6,  8'hF0, 8'h0F, 6'h21, 8'h00, 6'h23, 6'h1E}, // R4 and, C/H kept
    {5'd7,  8'h80, 8'h01, 6'h08, 8'h81, 6'h14, 6'h1E}, // R4 or, V cleared
    {5'd8,  8'hAA, 8'hAA, 6'h00, 8'h00, 6'h02, 6'h1E}, // R4 xor
    {5'd11, 8'h7F, 8'h00, 6'h01, 8'h80, 6'h0D, 6'h1E}, // R5 inc overflow
    {5'd12, 8'h80, 8'h00, 6'h20, 8'h7F, 6'h38, 6'h1E}, // R5 dec overflow
    {5'd12, 8'h01, 8'h00, 6'h00, 8'h00, 6'h02, 6'h1E}, // R5 dec to zero
    {5'd9,  8'h0F, 8'h00, 6'h20, 8'hF0, 6'h35, 6'h1F}, // R6 complement
    {5'd10, 8'h01, 8'h00, 6'h00, 8'hFF, 6'h35, 6'h3F}, // R7 negate one
    {5'd10, 8'h80, 8'h00, 6'h00, 8'h80, 6'h0D, 6'h3F}, // R7 negate 0x80
    {5'd10, 8'h00, 8'h00, 6'h00, 8'h00, 6'h02, 6'h3F}, // R7 negate zero
    {5'd13, 8'h81, 8'h00, 6'h20, 8'h02, 6'h39, 6'h1F}, // R8 shift left
    {5'd14, 8'h01, 8'h00, 6'h00, 8'h00, 6'h1B, 6'h1F}, // R8 shift right
    {5'd15, 8'h40, 8'h00, 6'h01, 8'h81, 6'h0C, 6'h1F}, // R9 rotate left
    {5'd16, 8'h02, 8'h00, 6'h01, 8'h81, 6'h0C, 6'h1F}, // R9 rotate right
    {5'd16, 8'h01, 8'h00, 6'h00, 8'h00, 6'h1B, 6'h1F}, // R9 rotate to zero
    {5'd17, 8'h3C, 8'h55, 6'h2A, 8'h3C, 6'h2A, 6'h00}  // R11 unused code
  };

  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [5:0] fi);
    @(posedge clk);
    #1;
    op_sel = op; opnd_a = a; opnd_b = b; flags_in = fi;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] er, input logic [5:0] ef,
                       input logic [5:0] em);
    n_chk++;
    if (result !== er || flags_out !== ef || flags_we !== em) begin
      n_fail++;
      $display("FAIL %s: res=%h flags=%h mask=%h expected res=%h flags=%h mask=%h",
               req, result, flags_out, flags_we, er, ef, em);
    end
  endtask

  initial begin
    op_sel = 5'd0; opnd_a = 8'h00; opnd_b = 8'h00; flags_in = 6'h00;
    @(negedge clk);
    check("R10 initial zero add", 8'h00, 6'h02, 6'h3F);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][46:42], VEC[i][41:34], VEC[i][33:26], VEC[i][25:20]);
      check($sformatf("vector %0d (R1..R11 table)", i), VEC[i][19:12], VEC[i][11:6], VEC[i][5:0]);
    end
    // R11: unmasked flags pass through for every incoming pattern on an unused code
    for (int f = 0; f < 64; f++) begin
      apply(5'd31, 8'h99, 8'h11, 6'(f));
      check("R11 pass-through", 8'h99, 6'(f), 6'h00);
    end
    // R4: C and H retained both ways on AND
    apply(5'd6, 8'hFF, 8'hFF, 6'h21);
    check("R4 and keeps C/H", 8'hFF, 6'h35, 6'h1E);
    // R8: left shift with C set in must still fill zero
    apply(5'd13, 8'h00, 8'h00, 6'h01);
    check("R8 lsl zero fill", 8'h00, 6'h02, 6'h1F);
    // R9: rotate right brings incoming C to bit 7
    apply(5'd16, 8'h00, 8'h00, 6'h01);
    check("R9 ror carry to msb", 8'h80, 6'h0C, 6'h1F);
    // R5: inc from 0xFF keeps C=0/H=0, wraps to zero
    apply(5'd11, 8'hFF, 8'h00, 6'h00);
    check("R5 inc wrap", 8'h00, 6'h02, 6'h1E);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
    end
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule